// File: doc/BRIEF.md
# Watchdog Reset Generator

This block is a watchdog that a host keeps alive by writing a byte register over a simple register bus. It counts down an 8-bit timeout value in whole seconds or whole minutes, derived from an external one-millisecond tick strobe. If the host stops rewriting the timeout before the count runs out, the block asserts an active-low reset output. That output can either stay low until software intervenes, or fire once as a pulse of one of four selectable widths.

A sticky status flag records that the watchdog expired. The flag lives in a power-on domain, so it survives the host reset that the watchdog itself usually triggers, and boot code can read it. A separate enable bit gates the output pin, and counting also depends on a device-level enable bit. Register writes take effect at the clock edge on which `bus_we` is sampled high. Reads are combinational from `bus_addr`. Register addresses: 0x30 device enable (bit 0), 0xF0 pin configuration (bit 7 pin enable), 0xF5 control, 0xF6 timeout count.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset every register (0x30, 0xF0, 0xF5, 0xF6) reads 0x00 and `wdt_rst_n` is high.
- R2: With seconds selected, the timeout expires exactly N*TICKS_PER_SEC tick strobes after a write of N to 0xF6, and 0xF6 reads back the remaining count, which drops by one per elapsed second.
- R3: Control bit 3 (0xF5) set to 1 makes the count unit one minute (TICKS_PER_SEC*SECS_PER_MIN ticks); 0 selects seconds.
- R4: Writing 0xF6 is the keepalive: it reloads the count and restarts the current unit from zero, so expiry is pushed out by the full new timeout.
- R5: The count advances only when both the watchdog enable (0xF5 bit 5) and the device enable (0x30 bit 0) are 1; otherwise the count read from 0xF6 holds and no reset is produced.
- R6: A timeout value of zero never counts and never expires.
- R7: While counting is stopped, the unit prescaler is cleared, so after re-enabling the next decrement comes a full unit later.
- R8: In level mode (0xF5 bit 4 = 0), the reset output stays low after expiry until the watchdog enable is cleared or 0xF6 is rewritten.
- R9: In pulse mode (0xF5 bit 4 = 1), the output goes low for a width set by 0xF5 bits 1:0: code 0 = 1 tick, 1 = 25 ticks, 2 = 125 ticks, 3 = 5000 ticks, then returns high.
- R10: The pin reflects the internal reset request only while 0xF0 bit 7 is 1; when it is 0, `wdt_rst_n` stays high.
- R11: Expiry sets 0xF5 bit 6. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R12: The status bit survives the host reset `rst_n`, which clears all other state, and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| rst_n | input | 1 | Host reset, active low, synchronous; clears everything except the status bit |
| tick_ms | input | 1 | One-millisecond tick strobe, one cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| wdt_rst_n | output | 1 | Watchdog reset output, active low |

## Verification
The countdown is tried with several timeout values in both units, and expiry is checked on the exact tick: one strobe early the pin must still be high. This separates a correct prescaler from one that is off by one or uses the wrong unit. A keepalive written one unit before expiry, and a disable/re-enable made partway through a unit, show apart a prescaler that restarts from one that keeps its stale phase. Each of the four pulse codes is measured for both edges of the pulse. Level mode is released by each of its two causes, and the status flag is driven through host reset and power-on reset to show which domain it belongs to.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
   // register addresses
   localparam logic [7:0] A_DEVEN  = 8'h30;
   localparam logic [7:0] A_PINCFG = 8'hF0;
   localparam logic [7:0] A_CTRL   = 8'hF5;
   localparam logic [7:0] A_TIME   = 8'hF6;

   // bit positions
   localparam int BIT_DEVEN = 0;
   localparam int BIT_PINEN = 7;
   localparam int BIT_STS   = 6;
   localparam int BIT_EN    = 5;
   localparam int BIT_PULSE = 4;
   localparam int BIT_UNIT  = 3;

   typedef struct packed {
      logic       en;
      logic       pulse;
      logic       unit;
      logic [1:0] pw;
   } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int TO_W = 8
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            srst,
   input  logic            we,
   input  logic [7:0]      addr,
   input  logic [7:0]      wdata,
   input  logic            expire,
   input  logic [TO_W-1:0] cnt,
   output ctrl_t           ctrl,
   output logic            dev_en,
   output logic            pin_en,
   output logic            sts,
   output logic            load,
   output logic [TO_W-1:0] load_val,
   output logic [7:0]      rdata
);
   if (TO_W < 1 || TO_W > 8) begin : g_bad_tow
      $error("wdt_regs: TO_W must be within 1..8");
   end

   logic wr_ctrl, wr_dev, wr_pin, sts_clr;

   always_comb begin
      wr_ctrl = we && (addr == A_CTRL);
      wr_dev  = we && (addr == A_DEVEN);
      wr_pin  = we && (addr == A_PINCFG);
      load    = we && (addr == A_TIME);
      sts_clr = wr_ctrl && wdata[BIT_STS];
   end

   assign load_val = wdata[TO_W-1:0];

   // host-domain configuration
   always_ff @(posedge clk) begin
      if (srst) begin
         ctrl   <= '0;
         dev_en <= 1'b0;
         pin_en <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl.en    <= wdata[BIT_EN];
            ctrl.pulse <= wdata[BIT_PULSE];
            ctrl.unit  <= wdata[BIT_UNIT];
            ctrl.pw    <= wdata[1:0];
         end
         if (wr_dev) dev_en <= wdata[BIT_DEVEN];
         if (wr_pin) pin_en <= wdata[BIT_PINEN];
      end
   end

   // power-on domain status flag, set wins over clear
   always_ff @(posedge clk) begin
      if (!por_n)       sts <= 1'b0;
      else if (expire)  sts <= 1'b1;
      else if (sts_clr) sts <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_DEVEN:  rdata[BIT_DEVEN] = dev_en;
         A_PINCFG: rdata[BIT_PINEN] = pin_en;
         A_CTRL:   rdata = {1'b0, sts, ctrl.en, ctrl.pulse, ctrl.unit, 1'b0, ctrl.pw};
         A_TIME:   rdata = 8'(cnt);
         default:  rdata = '0;
      endcase
   end

   p_sts_set_r11: assert property (@(posedge clk) disable iff (!por_n)
      expire |=> sts);
   p_sts_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
      (sts && !(we && addr == A_CTRL && wdata[BIT_STS])) |=> sts);
   p_sts_keep_hostrst_r12: assert property (@(posedge clk) disable iff (!por_n)
      (srst && sts) |=> sts);
endmodule

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale #(
   parameter int TICKS_PER_SEC = 1000,
   parameter int SECS_PER_MIN  = 60
) (
   input  logic clk,
   input  logic srst,
   input  logic run,
   input  logic restart,
   input  logic tick,
   input  logic unit_min,
   output logic unit_stb
);
   localparam int MIN_TICKS = TICKS_PER_SEC * SECS_PER_MIN;
   localparam int PS_W      = $clog2(MIN_TICKS);

   if (TICKS_PER_SEC < 2) begin : g_bad_tps
      $error("wdt_prescale: TICKS_PER_SEC must be at least 2");
   end
   if (SECS_PER_MIN < 1) begin : g_bad_spm
      $error("wdt_prescale: SECS_PER_MIN must be at least 1");
   end

   localparam logic [PS_W-1:0] SEC_LIM = PS_W'(TICKS_PER_SEC - 1);
   localparam logic [PS_W-1:0] MIN_LIM = PS_W'(MIN_TICKS - 1);

   logic [PS_W-1:0] ps_q;
   logic [PS_W-1:0] lim;
   logic            at_lim;

   assign lim    = unit_min ? MIN_LIM : SEC_LIM;
   assign at_lim = (ps_q >= lim);

   always_ff @(posedge clk) begin
      if (srst || !run || restart) ps_q <= '0;
      else if (tick)               ps_q <= at_lim ? '0 : ps_q + 1'b1;
   end

   assign unit_stb = run && tick && at_lim && !restart;

   p_idle_clear_r7: assert property (@(posedge clk) disable iff (srst)
      !run |=> (ps_q == '0));
   p_restart_clear_r4: assert property (@(posedge clk) disable iff (srst)
      restart |=> (ps_q == '0));
   p_in_range_r3: assert property (@(posedge clk) disable iff (srst)
      1'b1 |-> (ps_q <= MIN_LIM));
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
   parameter int TO_W = 8
) (
   input  logic            clk,
   input  logic            srst,
   input  logic            load,
   input  logic [TO_W-1:0] load_val,
   input  logic            run,
   input  logic            unit_stb,
   output logic [TO_W-1:0] cnt,
   output logic            expire
);
   localparam logic [TO_W-1:0] ONE = TO_W'(1);

   always_ff @(posedge clk) begin
      if (srst)                           cnt <= '0;
      else if (load)                      cnt <= load_val;
      else if (run && unit_stb && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign expire = run && unit_stb && !load && (cnt == ONE);

   p_reload_r4: assert property (@(posedge clk) disable iff (srst)
      load |=> (cnt == $past(load_val)));
   p_zero_hold_r6: assert property (@(posedge clk) disable iff (srst)
      (cnt == '0 && !load) |=> (cnt == '0));
   p_frozen_r5: assert property (@(posedge clk) disable iff (srst)
      (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/wdt_outgen.sv
`timescale 1ns/1ps
module wdt_outgen #(
   parameter int unsigned PULSE_TICKS [4] = '{1, 25, 125, 5000}
) (
   input  logic       clk,
   input  logic       srst,
   input  logic       tick,
   input  logic       expire,
   input  logic       pulse_mode,
   input  logic [1:0] pw,
   input  logic       release_lvl,
   output logic       req
);
   localparam int unsigned M01  = (PULSE_TICKS[0] > PULSE_TICKS[1]) ? PULSE_TICKS[0] : PULSE_TICKS[1];
   localparam int unsigned M23  = (PULSE_TICKS[2] > PULSE_TICKS[3]) ? PULSE_TICKS[2] : PULSE_TICKS[3];
   localparam int unsigned PMAX = (M01 > M23) ? M01 : M23;
   localparam int          PC_W = $clog2(PMAX + 1);

   logic [PC_W-1:0] wtab [4];

   for (genvar i = 0; i < 4; i++) begin : g_wtab
      if (PULSE_TICKS[i] == 0) begin : g_bad_w
         $error("wdt_outgen: pulse widths must be non-zero");
      end
      assign wtab[i] = PC_W'(PULSE_TICKS[i]);
   end

   logic            level_on;
   logic [PC_W-1:0] pulse_left;

   always_ff @(posedge clk) begin
      if (srst)                         level_on <= 1'b0;
      else if (release_lvl)             level_on <= 1'b0;
      else if (expire && !pulse_mode)   level_on <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (srst)                              pulse_left <= '0;
      else if (expire && pulse_mode)         pulse_left <= wtab[pw];
      else if (tick && pulse_left != '0)     pulse_left <= pulse_left - 1'b1;
   end

   assign req = level_on || (pulse_left != '0);

   p_level_hold_r8: assert property (@(posedge clk) disable iff (srst)
      (level_on && !release_lvl) |=> level_on);
   p_pulse_load_r9: assert property (@(posedge clk) disable iff (srst)
      (expire && pulse_mode) |=> (pulse_left == wtab[$past(pw)]));
   p_pulse_wait_r9: assert property (@(posedge clk) disable iff (srst)
      (pulse_left != '0 && !tick && !expire) |=> $stable(pulse_left));
endmodule

// File: rtl/wdt_top.sv
`timescale 1ns/1ps
module wdt_top
   import wdt_pkg::*;
#(
   parameter int          TO_W            = 8,
   parameter int          TICKS_PER_SEC   = 1000,
   parameter int          SECS_PER_MIN    = 60,
   parameter int unsigned PULSE_TICKS [4] = '{1, 25, 125, 5000}
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic       bus_we,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       wdt_rst_n
);
   logic            srst;
   ctrl_t           ctrl;
   logic            dev_en, pin_en, sts;
   logic            load;
   logic [TO_W-1:0] load_val, cnt;
   logic            run, unit_stb, expire, release_lvl, req;

   assign srst        = !rst_n || !por_n;
   assign run         = ctrl.en && dev_en;
   assign release_lvl = load || (bus_we && bus_addr == A_CTRL && !bus_wdata[BIT_EN]);

   wdt_regs #(.TO_W(TO_W)) u_regs (
      .clk(clk), .por_n(por_n), .srst(srst),
      .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .expire(expire), .cnt(cnt),
      .ctrl(ctrl), .dev_en(dev_en), .pin_en(pin_en), .sts(sts),
      .load(load), .load_val(load_val), .rdata(bus_rdata)
   );

   wdt_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)) u_ps (
      .clk(clk), .srst(srst), .run(run), .restart(load),
      .tick(tick_ms), .unit_min(ctrl.unit), .unit_stb(unit_stb)
   );

   wdt_countdown #(.TO_W(TO_W)) u_cd (
      .clk(clk), .srst(srst), .load(load), .load_val(load_val),
      .run(run), .unit_stb(unit_stb), .cnt(cnt), .expire(expire)
   );

   wdt_outgen #(.PULSE_TICKS(PULSE_TICKS)) u_og (
      .clk(clk), .srst(srst), .tick(tick_ms), .expire(expire),
      .pulse_mode(ctrl.pulse), .pw(ctrl.pw), .release_lvl(release_lvl),
      .req(req)
   );

   assign wdt_rst_n = !(req && pin_en);

   p_expire_drives_pin_r10: assert property (@(posedge clk) disable iff (srst)
      (expire && pin_en && !bus_we) |=> !wdt_rst_n);
   p_no_expire_idle_r5: assert property (@(posedge clk) disable iff (srst)
      (!run && !sts) |=> !sts);
endmodule

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
   localparam int TPS = 4;
   localparam int SPM = 3;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b1;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       wdt_rst_n;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   wdt_top #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM)) u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_ms(tick_ms),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wdt_rst_n(wdt_rst_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int k);
      repeat (k) @(negedge clk);
   endtask

   // caller sits at a negedge; write lands on the next posedge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic arm(input logic [7:0] n, input logic [7:0] ctl);
      wr(8'h30, 8'h01);
      wr(8'hF0, 8'h80);
      wr(8'hF5, ctl);
      wr(8'hF6, n);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(8'h30, d); check("R1 dev reg", d, 0);
      rd(8'hF0, d); check("R1 pin reg", d, 0);
      rd(8'hF5, d); check("R1 ctrl reg", d, 0);
      rd(8'hF6, d); check("R1 time reg", d, 0);
      check("R1 pin idle", wdt_rst_n, 1);
   endtask

   task automatic t_seconds;
      logic [7:0] d;
      arm(8'd3, 8'h20);
      rd(8'hF6, d); check("R2 loaded count", d, 3);
      wait_n(4*3 - 1);
      check("R2 one tick early", wdt_rst_n, 1);
      rd(8'hF6, d); check("R2 remaining count", d, 1);
      wait_n(1);
      check("R2 expiry edge", wdt_rst_n, 0);
      rd(8'hF5, d); check("R11 status set", d[6], 1);
      wait_n(50);
      check("R8 level held", wdt_rst_n, 0);
      wr(8'hF6, 8'd2);
      check("R8 released by rewrite", wdt_rst_n, 1);
      wr(8'hF5, 8'h00);
      rd(8'hF5, d); check("R11 write 0 keeps status", d[6], 1);
      wr(8'hF5, 8'h40);
      rd(8'hF5, d); check("R11 write 1 clears status", d[6], 0);
   endtask

   task automatic t_keepalive;
      arm(8'd2, 8'h20);
      wait_n(6);
      wr(8'hF6, 8'd2);
      wait_n(7);
      check("R4 not yet expired", wdt_rst_n, 1);
      wait_n(1);
      check("R4 expires full timeout after keepalive", wdt_rst_n, 0);
      wr(8'hF5, 8'h40);
      check("R8 released by enable clear", wdt_rst_n, 1);
   endtask

   task automatic t_minutes;
      logic [7:0] d;
      arm(8'd1, 8'h28);
      wait_n(TPS*SPM - 1);
      check("R3 minute not yet", wdt_rst_n, 1);
      wait_n(1);
      check("R3 minute expiry", wdt_rst_n, 0);
      wr(8'hF5, 8'h40);
      check("R8 release minute level", wdt_rst_n, 1);
      rd(8'hF5, d); check("R11 cleared after minute", d[6], 0);
   endtask

   task automatic t_zero;
      logic [7:0] d;
      arm(8'd0, 8'h20);
      wait_n(40);
      check("R6 zero no reset", wdt_rst_n, 1);
      rd(8'hF5, d); check("R6 zero no status", d[6], 0);
      rd(8'hF6, d); check("R6 zero holds", d, 0);
      wr(8'hF5, 8'h00);
   endtask

   task automatic t_enables;
      logic [7:0] d;
      wr(8'h30, 8'h00);
      wr(8'hF5, 8'h20);
      wr(8'hF6, 8'd2);
      wait_n(30);
      check("R5 device off no reset", wdt_rst_n, 1);
      rd(8'hF6, d); check("R5 device off count held", d, 2);
      wr(8'h30, 8'h01);
      wr(8'hF5, 8'h00);
      wr(8'hF6, 8'd2);
      wait_n(30);
      check("R5 wd off no reset", wdt_rst_n, 1);
      rd(8'hF6, d); check("R5 wd off count held", d, 2);
      rd(8'hF5, d); check("R5 no status", d[6], 0);
   endtask

   task automatic t_prescale;
      logic [7:0] d;
      arm(8'd3, 8'h20);
      wait_n(5);
      wr(8'hF5, 8'h00);
      wait_n(3);
      rd(8'hF6, d); check("R7 count while stopped", d, 2);
      wr(8'hF5, 8'h20);
      wait_n(7);
      check("R7 full unit after re-enable", wdt_rst_n, 1);
      wait_n(1);
      check("R7 expiry after re-enable", wdt_rst_n, 0);
      wr(8'hF5, 8'h40);
   endtask

   task automatic t_pulse;
      int widths [4] = '{1, 25, 125, 5000};
      for (int code = 0; code < 4; code++) begin
         wr(8'h30, 8'h01);
         wr(8'hF0, 8'h80);
         wr(8'hF5, 8'h30 | 8'(code));
         wr(8'hF6, 8'd1);
         wait_n(TPS - 1);
         check($sformatf("R9 code %0d before", code), wdt_rst_n, 1);
         wait_n(1);
         check($sformatf("R9 code %0d start", code), wdt_rst_n, 0);
         if (widths[code] > 1) begin
            wait_n(widths[code] - 1);
            check($sformatf("R9 code %0d last low", code), wdt_rst_n, 0);
         end
         wait_n(1);
         check($sformatf("R9 code %0d end", code), wdt_rst_n, 1);
         wr(8'hF5, 8'h40);
      end
   endtask

   task automatic t_pin;
      logic [7:0] d;
      wr(8'h30, 8'h01);
      wr(8'hF0, 8'h00);
      wr(8'hF5, 8'h20);
      wr(8'hF6, 8'd1);
      wait_n(8);
      check("R10 gated pin high", wdt_rst_n, 1);
      rd(8'hF5, d); check("R10 expired behind gate", d[6], 1);
      wr(8'hF0, 8'h80);
      check("R10 gate opened", wdt_rst_n, 0);
      wr(8'hF5, 8'h40);
   endtask

   task automatic t_resets;
      logic [7:0] d;
      arm(8'd1, 8'h20);
      wait_n(4);
      check("R12 expired before reset", wdt_rst_n, 0);
      rst_n = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      rd(8'hF5, d); check("R12 status survives host reset", d, 8'h40);
      check("R12 pin high after host reset", wdt_rst_n, 1);
      por_n = 1'b0;
      wait_n(3);
      por_n = 1'b1;
      rd(8'hF5, d); check("R12 por clears status", d, 0);
   endtask

   initial begin
      wait_n(4);
      por_n = 1'b1;
      rst_n = 1'b1;
      wait_n(1);
      t_reset();
      t_seconds();
      t_keepalive();
      t_minutes();
      t_zero();
      t_enables();
      t_prescale();
      t_pulse();
      t_pin();
      t_resets();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog timeout actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule